// File: doc/BRIEF.md
# Two-Group Secure Interrupt Acknowledge Interface

This block is the per-processor side of an interrupt controller. Each cycle it receives the single winning pending interrupt from the distributor: its ID, priority and group. It decides whether to signal that interrupt to the processor, and on which line: the normal interrupt line or the fast interrupt line. It also serves the processor's register accesses. The processor can read the acknowledge and highest-pending registers and write the end-of-interrupt register. Each access carries a secure or non-secure attribute. That attribute, the interrupt's group and two control bits decide what each access may see and change.

The control register is banked. The secure view holds four bits. The non-secure view aliases only the group 1 enable. The priority mask and the running priority value are shown to non-secure software in a halved, shifted form. Acknowledges and completions are reported to the distributor as single-cycle pulses that carry the interrupt ID. Requests enter over a valid/ready channel. Every accepted request, read or write, returns exactly one response beat over a valid/ready channel. A new request is refused while a response is waiting and the consumer has not taken it, so back-pressure on the response side stalls the request side.

Top module: `cpuif_grp_sec`

## Requirements
- R1: After reset the control register and the priority mask are zero, irq_o, fiq_o, ack_o and eoi_o are low, rsp_valid is low and req_ready is high.
- R2: A request is accepted on a cycle where req_valid and req_ready are both high, and its response appears on rsp_valid in the next cycle. While rsp_valid is high and rsp_ready is low, rsp_rdata holds and req_ready is low. Writes return a response with rdata 0.
- R3: The acknowledge register is req_sel 2. When the pending interrupt is group 0 (pend_grp 0), a secure read returns its ID and pulses ack_o with ack_id. A non-secure read returns 1023 and does not pulse ack_o.
- R4: When the pending interrupt is group 1, a non-secure acknowledge read returns its ID and pulses ack_o. A secure read does the same only if the acknowledge-control bit is set. Otherwise the secure read returns 1022 and does not pulse ack_o.
- R5: The pending interrupt is not visible when pend_valid is low, when its group's enable is clear, or when pend_prio is not numerically below the priority mask. In that case acknowledge and highest-pending reads return 1023 and no pulse occurs.
- R6: The highest-pending register is req_sel 4. Reads of it return the same code as an acknowledge read would, and they never pulse ack_o.
- R7: The end-of-interrupt register is req_sel 3, written with the ID in req_wdata and the interrupt's group on eoi_grp. A non-secure write for a group 0 interrupt is ignored. Every other write pulses eoi_o with eoi_id equal to the written ID, including a secure write for a group 1 interrupt while acknowledge-control is clear.
- R8: The control register is req_sel 0. The secure view has bit 0 as the group 0 enable, bit 1 as the group 1 enable, bit 2 as acknowledge-control and bit 3 as fast-interrupt-enable. The non-secure view shows the group 1 enable in bit 0, and a non-secure write changes only that enable.
- R9: A visible interrupt is signalled on fiq_o when it is group 0 and fast-interrupt-enable is set. Otherwise it is signalled on irq_o. The two lines are never high together, and they follow their inputs with one cycle of latency.
- R10: irq_o and fiq_o are both low when the pending interrupt is not visible (see R5), in particular when its group's enable is clear.
- R11: The priority mask is req_sel 1. Secure accesses read and write all 8 bits. A non-secure read returns {mask[6:0],0} if mask bit 7 is set, and 0 otherwise. A non-secure write stores {1,wdata[7:1]} only if mask bit 7 is set, and is otherwise ignored.
- R12: The running priority register is req_sel 5 and reports the run_prio input. A secure read returns it unchanged. A non-secure read applies the same shifted view as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access is secure |
| req_sel | input | 3 | Register select (0 ctrl, 1 mask, 2 ack, 3 eoi, 4 highest-pending, 5 running priority) |
| req_wdata | input | 10 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pend_valid | input | 1 | A pending interrupt is offered |
| pend_id | input | 10 | ID of the highest-priority pending interrupt |
| pend_prio | input | 8 | Its priority (lower value = more urgent) |
| pend_grp | input | 1 | Its group |
| eoi_grp | input | 1 | Group of the interrupt named on req_wdata |
| run_prio | input | 8 | Current running priority |
| ack_o | output | 1 | Acknowledge pulse |
| ack_id | output | 10 | ID acknowledged |
| eoi_o | output | 1 | Completion pulse |
| eoi_id | output | 10 | ID completed |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A corrupted banked control bit shows up on the interrupt lines one cycle after the stimulus. It also shows up at the next acknowledge read, because the returned code moves among the real ID, 1022 and 1023. A wrong priority-mask value shows the same way, as a line that stays dark or a spurious code. A non-secure write that leaks into secure state is caught by a secure read of the same register on the very next access. A stuck response register appears as req_ready staying low or as rdata changing under back-pressure, in the cycle right after the stall begins.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_PMASK  = 3'd1,
    SEL_ACK    = 3'd2,
    SEL_EOI    = 3'd3,
    SEL_HPEND  = 3'd4,
    SEL_RUNPRI = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic fiq_en;
    logic ack_ctl;
    logic en_g1;
    logic en_g0;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cpuif_bank.sv
module cpuif_bank
  import cpuif_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic              secure,
  input  logic [PRIO_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [PRIO_W-1:0] pmask,
  output logic [DATA_W-1:0] ctrl_view,
  output logic [DATA_W-1:0] pmask_view
);

  ctrl_t             ctrl_q;
  logic [PRIO_W-1:0] pmask_q;
  logic              pmask_top;

  assign pmask_top = pmask_q[PRIO_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pmask_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) begin
        if (secure) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        else        ctrl_q.en_g1 <= wdata[0];
      end
      if (sel == SEL_PMASK) begin
        if (secure)         pmask_q <= wdata;
        else if (pmask_top) pmask_q <= {1'b1, wdata[PRIO_W-1:1]};
      end
    end
  end

  always_comb begin
    ctrl_view  = '0;
    pmask_view = '0;
    if (secure) begin
      ctrl_view[CTRL_W-1:0]  = ctrl_q;
      pmask_view[PRIO_W-1:0] = pmask_q;
    end else begin
      ctrl_view[0] = ctrl_q.en_g1;
      if (pmask_top) pmask_view[PRIO_W-1:0] = {pmask_q[PRIO_W-2:0], 1'b0};
    end
  end

  assign ctrl  = ctrl_q;
  assign pmask = pmask_q;

  p_ns_keeps_secure_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && sel == SEL_CTRL) |=>
      ($stable(ctrl_q.en_g0) && $stable(ctrl_q.ack_ctl) && $stable(ctrl_q.fiq_en)));

  p_ns_mask_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && sel == SEL_PMASK && !pmask_top) |=> $stable(pmask_q));

  p_ns_mask_top_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && sel == SEL_PMASK && pmask_top) |=> pmask_q[PRIO_W-1]);

endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              pend_valid,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_grp,
  input  ctrl_t             ctrl,
  input  logic [PRIO_W-1:0] pmask,
  input  logic              secure,
  output logic              vis,
  output logic              grant,
  output logic [ID_W-1:0]   resp_id
);

  localparam logic [ID_W-1:0] ID_NONE   = '1;
  localparam logic [ID_W-1:0] ID_HIDDEN = ID_NONE - 1'b1;

  logic grp_on;

  assign grp_on = pend_grp ? ctrl.en_g1 : ctrl.en_g0;
  assign vis    = pend_valid && grp_on && (pend_prio < pmask);

  always_comb begin
    grant   = 1'b0;
    resp_id = ID_NONE;
    if (vis) begin
      if (!pend_grp) begin
        if (secure) begin
          grant   = 1'b1;
          resp_id = pend_id;
        end
      end else if (!secure || ctrl.ack_ctl) begin
        grant   = 1'b1;
        resp_id = pend_id;
      end else begin
        resp_id = ID_HIDDEN;
      end
    end
  end

endmodule

// File: rtl/cpuif_line.sv
module cpuif_line (
  input  logic clk,
  input  logic rst_n,
  input  logic vis,
  input  logic grp,
  input  logic fiq_en,
  output logic irq_o,
  output logic fiq_o
);

  logic to_fast;

  assign to_fast = !grp && fiq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= vis && !to_fast;
      fiq_o <= vis && to_fast;
    end
  end

  p_lines_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));

  p_fast_only_grp0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(!grp && fiq_en));

  p_dark_when_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!vis) |-> (!irq_o && !fiq_o));

endmodule

// File: rtl/cpuif_grp_sec.sv
module cpuif_grp_sec
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [2:0]        req_sel,
  input  logic [ID_W-1:0]   req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pend_valid,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_grp,
  input  logic              eoi_grp,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int ID_PAD = DATA_W - ID_W;
  localparam int PR_PAD = DATA_W - PRIO_W;

  reg_sel_e          sel;
  logic              acc;
  ctrl_t             ctrl;
  logic [PRIO_W-1:0] pmask;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] pmask_view;
  logic              vis;
  logic              grant;
  logic [ID_W-1:0]   resp_id;
  logic [PRIO_W-1:0] run_view;
  logic [DATA_W-1:0] rd_mux;
  logic              eoi_ok;

  assign sel       = reg_sel_e'(req_sel);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  cpuif_bank #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (acc && req_write),
    .sel        (sel),
    .secure     (req_secure),
    .wdata      (req_wdata[PRIO_W-1:0]),
    .ctrl       (ctrl),
    .pmask      (pmask),
    .ctrl_view  (ctrl_view),
    .pmask_view (pmask_view)
  );

  cpuif_gate #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_gate (
    .pend_valid (pend_valid),
    .pend_id    (pend_id),
    .pend_prio  (pend_prio),
    .pend_grp   (pend_grp),
    .ctrl       (ctrl),
    .pmask      (pmask),
    .secure     (req_secure),
    .vis        (vis),
    .grant      (grant),
    .resp_id    (resp_id)
  );

  cpuif_line u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .vis    (vis),
    .grp    (pend_grp),
    .fiq_en (ctrl.fiq_en),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o)
  );

  always_comb begin
    if (req_secure)              run_view = run_prio;
    else if (run_prio[PRIO_W-1]) run_view = {run_prio[PRIO_W-2:0], 1'b0};
    else                         run_view = '0;
  end

  always_comb begin
    case (sel)
      SEL_CTRL:            rd_mux = ctrl_view;
      SEL_PMASK:           rd_mux = pmask_view;
      SEL_ACK, SEL_HPEND:  rd_mux = {{ID_PAD{1'b0}}, resp_id};
      SEL_RUNPRI:          rd_mux = {{PR_PAD{1'b0}}, run_view};
      default:             rd_mux = '0;
    endcase
  end

  assign eoi_ok = req_secure || eoi_grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ack_o     <= 1'b0;
      ack_id    <= '0;
      eoi_o     <= 1'b0;
      eoi_id    <= '0;
    end else begin
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= req_write ? '0 : rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      ack_o <= acc && !req_write && (sel == SEL_ACK) && grant;
      if (acc && !req_write && sel == SEL_ACK) ack_id <= pend_id;
      eoi_o <= acc && req_write && (sel == SEL_EOI) && eoi_ok;
      if (acc && req_write && sel == SEL_EOI) eoi_id <= req_wdata;
    end
  end

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_no_accept_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_ack_secure_grp0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(req_secure || pend_grp));

  p_ack_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(req_valid && !req_write && req_sel == 3'd2));

  p_eoi_ns_grp0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_o |-> $past(req_secure || eoi_grp));

endmodule

// File: tb/test_cpuif_grp_sec.sv
`timescale 1ns/1ps
module test_cpuif_grp_sec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_secure;
  logic [2:0]  req_sel;
  logic [9:0]  req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic        pend_valid;
  logic [9:0]  pend_id;
  logic [7:0]  pend_prio;
  logic        pend_grp, eoi_grp;
  logic [7:0]  run_prio;
  logic        ack_o, eoi_o, irq_o, fiq_o;
  logic [9:0]  ack_id, eoi_id;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cpuif_grp_sec i_cpuif_grp_sec (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_secure(req_secure), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pend_valid(pend_valid), .pend_id(pend_id), .pend_prio(pend_prio),
    .pend_grp(pend_grp), .eoi_grp(eoi_grp), .run_prio(run_prio),
    .ack_o(ack_o), .ack_id(ack_id), .eoi_o(eoi_o), .eoi_id(eoi_id),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic        sec;
    logic [2:0]  sel;
    logic        wr;
    logic [9:0]  wdata;
    logic        pv;
    logic [9:0]  pid;
    logic [7:0]  pprio;
    logic        pgrp;
    logic        egrp;
    logic [7:0]  run;
    logic [15:0] exp_rd;
    logic        exp_ack;
    logic        exp_eoi;
    logic        exp_irq;
    logic        exp_fiq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  // sec sel wr wdata | pv pid prio grp egrp run | rd ack eoi irq fiq | req
  localparam vec_t TBL [NV] = '{
    '{1,1,1,'hF0, 1,40,'h20,0,0,0,    0,   0,0,0,0, 11}, // R11 secure mask write
    '{1,0,1,'h1,  1,40,'h20,0,0,0,    0,   0,0,1,0, 8},  // R8 enable group 0
    '{1,2,0,0,    1,40,'h20,0,0,0,    40,  1,0,1,0, 3},  // R3 secure ack grp0
    '{0,2,0,0,    1,40,'h20,0,0,0,    1023,0,0,1,0, 3},  // R3 ns ack grp0 refused
    '{1,0,1,'h9,  1,40,'h20,0,0,0,    0,   0,0,0,1, 9},  // R9 fast line
    '{0,0,0,0,    1,40,'h20,0,0,0,    0,   0,0,0,1, 8},  // R8 ns view
    '{0,0,1,1,    1,40,'h20,0,0,0,    0,   0,0,0,1, 8},  // R8 ns sets g1 enable
    '{1,0,0,0,    1,40,'h20,0,0,0,    'hB, 0,0,0,1, 8},  // R8 secure view
    '{1,2,0,0,    1,77,'h30,1,0,0,    1022,0,0,1,0, 4},  // R4 hidden from secure
    '{0,4,0,0,    1,77,'h30,1,0,0,    77,  0,0,1,0, 6},  // R6 ns hpend grp1
    '{0,2,0,0,    1,77,'h30,1,0,0,    77,  1,0,1,0, 4},  // R4 ns ack grp1
    '{1,0,1,'hF,  1,77,'h30,1,0,0,    0,   0,0,1,0, 4},  // R4 set ack-control
    '{1,2,0,0,    1,77,'h30,1,0,0,    77,  1,0,1,0, 4},  // R4 secure ack grp1
    '{0,3,1,40,   1,77,'h30,1,0,0,    0,   0,0,1,0, 7},  // R7 ns eoi grp0 ignored
    '{1,3,1,40,   1,77,'h30,1,0,0,    0,   0,1,1,0, 7},  // R7 secure eoi grp0
    '{1,0,1,'h3,  1,77,'h30,1,0,0,    0,   0,0,1,0, 8},  // R8 clear ackctl/fiq
    '{1,3,1,77,   1,77,'h30,1,1,0,    0,   0,1,1,0, 7},  // R7 secure eoi grp1 ackctl 0
    '{0,0,1,0,    1,77,'h30,1,0,0,    0,   0,0,0,0, 10}, // R10 g1 disabled dark
    '{1,0,0,0,    1,77,'h30,1,0,0,    1,   0,0,0,0, 8},  // R8 only g1 cleared
    '{1,2,0,0,    1,77,'h30,1,0,0,    1023,0,0,0,0, 5},  // R5 group disabled
    '{1,4,0,0,    1,5,'hF0,0,0,0,     1023,0,0,0,0, 5},  // R5 masked priority
    '{0,1,0,0,    1,5,'h10,0,0,0,     'hE0,0,0,1,0, 11}, // R11 ns mask view
    '{1,4,0,0,    1,5,'h10,0,0,0,     5,   0,0,1,0, 6},  // R6 secure hpend no pulse
    '{0,1,1,'h40, 1,5,'h10,0,0,0,     0,   0,0,1,0, 11}, // R11 ns mask write
    '{1,1,0,0,    1,5,'h10,0,0,0,     'hA0,0,0,1,0, 11}, // R11 readback
    '{1,5,0,0,    1,5,'h10,0,0,'h90,  'h90,0,0,1,0, 12}, // R12 secure run prio
    '{0,5,0,0,    1,5,'h10,0,0,'h90,  'h20,0,0,1,0, 12}, // R12 ns shifted
    '{0,5,0,0,    1,5,'h10,0,0,'h50,  0,   0,0,1,0, 12}, // R12 ns low half
    '{1,0,1,'h9,  1,5,'h10,0,0,0,     0,   0,0,0,1, 9},  // R9 fiq for grp0
    '{0,4,0,0,    1,5,'h10,0,0,0,     1023,0,0,0,1, 6},  // R6 ns hpend grp0
    '{1,4,0,0,    0,5,'h10,0,0,0,     1023,0,0,0,0, 5}   // R5 nothing pending
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input bit sec, input bit [2:0] sel, input bit wr,
                        input bit [9:0] wd, input bit eg);
    @(negedge clk);
    req_secure = sec; req_sel = sel; req_write = wr; req_wdata = wd;
    eoi_grp = eg; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_sel = '0; req_wdata = '0; rsp_ready = 1'b1; pend_valid = 1'b0;
    pend_id = '0; pend_prio = '0; pend_grp = 1'b0; eoi_grp = 1'b0; run_prio = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!irq_o && !fiq_o && !ack_o && !eoi_o, "R1", "lines", {irq_o, fiq_o, ack_o, eoi_o}, 0);
    chk(!rsp_valid && req_ready, "R1", "handshake", {rsp_valid, req_ready}, 1);
    access(1, 0, 0, 0, 0);
    chk(rsp_valid && rsp_rdata == 0, "R1", "ctrl after reset", rsp_rdata, 0);
    access(1, 1, 0, 0, 0);
    chk(rsp_rdata == 0, "R1", "mask after reset", rsp_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk);
      pend_valid = v.pv; pend_id = v.pid; pend_prio = v.pprio;
      pend_grp = v.pgrp; run_prio = v.run;
      access(v.sec, v.sel, v.wr, v.wdata, v.egrp);
      chk(rsp_valid, $sformatf("R%0d v%0d", v.req, i), "rsp_valid", rsp_valid, 1);
      chk(rsp_rdata == 32'(v.exp_rd), $sformatf("R%0d v%0d", v.req, i), "rdata",
          rsp_rdata, v.exp_rd);
      chk(ack_o == v.exp_ack && (!v.exp_ack || ack_id == v.pid),
          $sformatf("R%0d v%0d", v.req, i), "ack", {ack_o, ack_id}, {v.exp_ack, v.pid});
      chk(eoi_o == v.exp_eoi && (!v.exp_eoi || eoi_id == v.wdata),
          $sformatf("R%0d v%0d", v.req, i), "eoi", {eoi_o, eoi_id}, {v.exp_eoi, v.wdata});
      @(negedge clk);
      chk(irq_o == v.exp_irq && fiq_o == v.exp_fiq, $sformatf("R%0d v%0d", v.req, i),
          "irq/fiq", {irq_o, fiq_o}, {v.exp_irq, v.exp_fiq});
    end

    // R11 ns mask write ignored while bit 7 clear
    access(1, 1, 1, 10'h60, 0);
    access(0, 1, 1, 10'hFF, 0);
    access(1, 1, 0, 0, 0);
    chk(rsp_rdata == 32'h60, "R11", "ns write ignored", rsp_rdata, 32'h60);
    access(0, 1, 0, 0, 0);
    chk(rsp_rdata == 0, "R11", "ns view low mask", rsp_rdata, 0);

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    access(1, 1, 0, 0, 0);
    chk(rsp_valid && !req_ready, "R2", "stall begins", {rsp_valid, req_ready}, 2'b10);
    req_secure = 1'b0; req_sel = 3'd0; req_write = 1'b1; req_wdata = 10'h1;
    req_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h60 && !req_ready, "R2", "held rdata",
        rsp_rdata, 32'h60);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R2", "drained", {rsp_valid, req_ready}, 2'b01);
    access(1, 0, 0, 0, 0);
    chk(rsp_rdata == 32'h9, "R2", "stalled write dropped", rsp_rdata, 32'h9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule